// File: doc/BRIEF.md
# Byte-Serial Memory and I/O Bus Bridge

This block sits between a 16-bit processor datapath and an external bus that carries a 16-bit address but only 8 bits of data. A request from the datapath can be a memory load, a memory store, an input from a device register or an output to one. Each request is turned into one or two 8-bit bus cycles. Words are built up, or taken apart, inside a 16-bit data register.

The same block decides where the address goes. For memory traffic it raises a memory-select flag and drives all 16 address lines. For device traffic it leaves memory-select low and drives only the low 8 lines. These carry a 4-bit device number above a 4-bit port number. The bus responder stretches any cycle by holding a ready input low. One clock after the last byte cycle, the block raises a single-cycle completion pulse.

A request is taken only while the block is idle. A load result stays on the read-data output until the next request is accepted.

Top module: `byte_bus_bridge`

## Requirements
- R1: While reset is held and in the first cycle after its release, `busRead`, `busWrite`, `memSel` and `done` are low, `idle` is high and `rdData` is zero.
- R2: A memory load (`reqKind`=2'b00) with `reqWord`=1 runs two read cycles, the first at `reqAddr` and the second at `reqAddr`+1. The first byte returned lands in bits 15:8 of `rdData` and the second in bits 7:0.
- R3: The second address of a memory word access wraps modulo 65536, so a word access at 16'hFFFF reads or writes 16'h0000 second.
- R4: A memory load with `reqWord`=0 runs one read cycle at `reqAddr` and returns the byte zero-extended in `rdData`.
- R5: A memory store (`reqKind`=2'b01) with `reqWord`=1 runs two write cycles. The first drives `reqWdata[15:8]` at `reqAddr` and the second drives `reqWdata[7:0]` at `reqAddr`+1.
- R6: A memory store with `reqWord`=0 runs one write cycle that drives `reqWdata[7:0]` at `reqAddr`.
- R7: During every memory bus cycle `memSel` is high and `busAddr` carries the full 16-bit address.
- R8: Device input (`reqKind`=2'b10) and output (`reqKind`=2'b11) run exactly one byte cycle whatever `reqWord` is, with `memSel` low. `busAddr` = {8'h00, `reqDev`, `reqPort`} and `reqAddr` is ignored. Input returns its byte zero-extended in `rdData`, and output drives `reqWdata[7:0]`.
- R9: A bus cycle ends only at a clock edge where `busReady` is high. While it is low, the address, strobes and write data hold steady.
- R10: `done` is high for exactly one clock, starting one clock after the edge that ends the final byte cycle. For n byte cycles each stalled s clocks, it is seen n*(s+1)+1 clocks after the accepting edge.
- R11: `reqValid` raised while the block is not idle is ignored: no extra bus cycle is run and the running result is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when `idle` is high |
| reqKind | input | 2 | 00 memory load, 01 memory store, 10 device input, 11 device output |
| reqWord | input | 1 | 1 selects a 16-bit memory transfer, 0 a byte |
| reqAddr | input | 16 | Memory byte address |
| reqDev | input | 4 | Device number for input/output |
| reqPort | input | 4 | Port number within the device |
| reqWdata | input | 16 | Store or output data |
| busAddr | output | 16 | External address, upper byte zero for device cycles |
| busWdata | output | 8 | External write byte |
| busRdata | input | 8 | External read byte |
| busRead | output | 1 | Read cycle in progress |
| busWrite | output | 1 | Write cycle in progress |
| memSel | output | 1 | High when the cycle targets memory |
| busReady | input | 1 | Responder completes the current byte cycle |
| rdData | output | 16 | Assembled load or input result |
| done | output | 1 | One-clock completion pulse |
| idle | output | 1 | Block can accept a request |

## Verification
Each request is accepted at one clock edge. Its first byte cycle is on the bus in the following clock. Every byte cycle then lasts the number of stall clocks plus one, and `done` and a settled `rdData` follow one clock after the final ready edge.

The bench sets the stall count for each vector. It counts falling edges from acceptance and requires `done` at exactly n*(s+1)+1. It logs each completed byte cycle at the falling edge where `busReady` is high and compares these logs with the expected address sequence.

// File: rtl/byte_bus_pkg.sv
package byte_bus_pkg;

  typedef enum logic [1:0] {
    OP_MEM_LOAD  = 2'b00,
    OP_MEM_STORE = 2'b01,
    OP_IO_IN     = 2'b10,
    OP_IO_OUT    = 2'b11
  } busOp_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seqState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic capture;   // latch a new request this edge
    logic capIo;     // new request is a device access
    logic capWrite;  // new request carries data out
    logic active;    // a byte cycle is on the bus
    logic phaseTwo;  // second byte of a word
    logic shiftIn;   // read byte completes this edge
    logic isIo;      // running access targets a device
    logic isWrite;   // running access writes
    logic isWord;    // running access is two bytes
  } ctlStrobe_t;

endpackage

// File: rtl/bbb_ctrl.sv
module bbb_ctrl
  import byte_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       reqWord,
  input  logic       busReady,
  output ctlStrobe_t strobe,
  output logic       busRead,
  output logic       busWrite,
  output logic       memSel,
  output logic       done,
  output logic       idle
);

  seqState_e stateQ;
  busOp_e    opQ;
  logic      wordQ;
  logic      doneQ;
  busOp_e    reqOp;

  assign reqOp = busOp_e'(reqKind);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      opQ    <= OP_MEM_LOAD;
      wordQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (reqValid) begin
            opQ    <= reqOp;
            // device accesses are always a single byte
            wordQ  <= reqWord && !reqKind[1];
            stateQ <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (busReady) begin
            if (wordQ) begin
              stateQ <= ST_SECOND;
            end else begin
              stateQ <= ST_IDLE;
              doneQ  <= 1'b1;
            end
          end
        end
        ST_SECOND: begin
          if (busReady) begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.capture  = (stateQ == ST_IDLE) && reqValid;
    strobe.capIo    = reqKind[1];
    strobe.capWrite = reqKind[0];
    strobe.active   = (stateQ != ST_IDLE);
    strobe.phaseTwo = (stateQ == ST_SECOND);
    strobe.isIo     = (opQ == OP_IO_IN) || (opQ == OP_IO_OUT);
    strobe.isWrite  = (opQ == OP_MEM_STORE) || (opQ == OP_IO_OUT);
    strobe.isWord   = wordQ;
    strobe.shiftIn  = strobe.active && busReady && !strobe.isWrite;
  end

  assign busRead  = strobe.active && !strobe.isWrite;
  assign busWrite = strobe.active && strobe.isWrite;
  assign memSel   = strobe.active && !strobe.isIo;
  assign done     = doneQ;
  assign idle     = (stateQ == ST_IDLE);

endmodule

// File: rtl/bbb_dpath.sv
module bbb_dpath
  import byte_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int DEV_W  = 4,
  parameter int PORT_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [DEV_W-1:0]          reqDev,
  input  logic [PORT_W-1:0]         reqPort,
  input  logic [2*BYTE_W-1:0]       reqWdata,
  input  logic [BYTE_W-1:0]         busRdata,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [BYTE_W-1:0]         busWdata,
  output logic [2*BYTE_W-1:0]       rdData
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int IO_W   = DEV_W + PORT_W;
  localparam int PAD_W  = ADDR_W - IO_W;

  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] dataQ;
  logic [ADDR_W-1:0] ioAddr;
  logic [ADDR_W-1:0] nextAddr;

  generate
    if (PAD_W > 0) begin : g_ioPad
      assign ioAddr = {{PAD_W{1'b0}}, reqDev, reqPort};
    end else begin : g_ioNoPad
      assign ioAddr = ADDR_W'({reqDev, reqPort});
    end
  endgenerate

  // second byte address wraps at the address width
  assign nextAddr = addrQ + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobe.capture) begin
      addrQ <= strobe.capIo ? ioAddr : reqAddr;
      dataQ <= strobe.capWrite ? reqWdata : '0;
    end else if (strobe.shiftIn) begin
      // earlier byte moves up, new byte enters the low lane
      dataQ <= {dataQ[BYTE_W-1:0], busRdata};
    end
  end

  always_comb begin
    busAddr = '0;
    if (strobe.active) begin
      if (strobe.isIo)          busAddr = addrQ;
      else if (strobe.phaseTwo) busAddr = nextAddr;
      else                      busAddr = addrQ;
    end
  end

  always_comb begin
    busWdata = '0;
    if (strobe.active && strobe.isWrite) begin
      if (strobe.isWord && !strobe.phaseTwo) busWdata = dataQ[WORD_W-1:BYTE_W];
      else                                   busWdata = dataQ[BYTE_W-1:0];
    end
  end

  assign rdData = dataQ;

endmodule

// File: rtl/byte_bus_bridge.sv
module byte_bus_bridge
  import byte_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int DEV_W  = 4,
  parameter int PORT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic                reqWord,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DEV_W-1:0]    reqDev,
  input  logic [PORT_W-1:0]   reqPort,
  input  logic [2*BYTE_W-1:0] reqWdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [BYTE_W-1:0]   busWdata,
  input  logic [BYTE_W-1:0]   busRdata,
  output logic                busRead,
  output logic                busWrite,
  output logic                memSel,
  input  logic                busReady,
  output logic [2*BYTE_W-1:0] rdData,
  output logic                done,
  output logic                idle
);

  ctlStrobe_t strobe;

  bbb_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqWord  (reqWord),
    .busReady (busReady),
    .strobe   (strobe),
    .busRead  (busRead),
    .busWrite (busWrite),
    .memSel   (memSel),
    .done     (done),
    .idle     (idle)
  );

  bbb_dpath #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .DEV_W  (DEV_W),
    .PORT_W (PORT_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqDev   (reqDev),
    .reqPort  (reqPort),
    .reqWdata (reqWdata),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .rdData   (rdData)
  );

endmodule

// File: rtl/bbb_checker.sv
module bbb_checker #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int DEV_W  = 4,
  parameter int PORT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BYTE_W-1:0] busWdata,
  input logic              busRead,
  input logic              busWrite,
  input logic              memSel,
  input logic              busReady,
  input logic              done,
  input logic              idle
);

  localparam int IO_W = DEV_W + PORT_W;

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    !(busRead && busWrite));  // R7

  AST_MEMSEL_ONLY_ON_BUS: assert property (@(posedge clk) disable iff (!rstN)
    memSel |-> (busRead || busWrite));  // R7

  AST_IO_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((busRead || busWrite) && !memSel) |-> ((busAddr >> IO_W) == '0));  // R8

  AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (memSel && $past(memSel) && $past(busReady)) |-> (busAddr == $past(busAddr) + ADDR_W'(1)));  // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((busRead || busWrite) && !busReady) |=>
      ((busRead || busWrite) && $stable(busAddr) && $stable(busWdata) && $stable(memSel)));  // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R10

  AST_DONE_AFTER_BUS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busRead || busWrite) && $past(busReady) && idle));  // R10

endmodule

bind byte_bus_bridge bbb_checker #(
  .ADDR_W (ADDR_W),
  .BYTE_W (BYTE_W),
  .DEV_W  (DEV_W),
  .PORT_W (PORT_W)
) u_bbbChecker (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRead  (busRead),
  .busWrite (busWrite),
  .memSel   (memSel),
  .busReady (busReady),
  .done     (done),
  .idle     (idle)
);

// File: tb/test_byte_bus_bridge.sv
`timescale 1ns/1ps
module test_byte_bus_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'b00;
  logic        reqWord = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [3:0]  reqDev = '0;
  logic [3:0]  reqPort = '0;
  logic [15:0] reqWdata = '0;
  logic [15:0] busAddr;
  logic [7:0]  busWdata;
  logic [7:0]  busRdata;
  logic        busRead, busWrite, memSel, busReady;
  logic [15:0] rdData;
  logic        done, idle;

  int checks = 0;
  int fails = 0;
  int stall = 0;
  int waitCnt = 0;
  int cycles = 0;

  logic [15:0] logAddr [8];
  logic [7:0]  logData [8];
  logic        logWr   [8];
  logic        logMem  [8];
  int          logN = 0;

  always #10 clk = ~clk;  // 50 MHz

  byte_bus_bridge i_byte_bus_bridge (.*);

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  // responder: returns a byte computed from the address, stalls each cycle
  assign busRdata = memByte(busAddr);
  assign busReady = (busRead || busWrite) && (waitCnt >= stall);

  always @(posedge clk) begin
    if (!(busRead || busWrite) || busReady) waitCnt <= 0;
    else                                     waitCnt <= waitCnt + 1;
  end

  always @(negedge clk) begin
    if ((busRead || busWrite) && busReady && logN < 8) begin
      logAddr[logN] = busAddr;
      logData[logN] = busWdata;
      logWr[logN]   = busWrite;
      logMem[logN]  = memSel;
      logN++;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
      finishRun();
    end
  end

  // kind[46:45] word[44] addr[43:28] dev[27:24] port[23:20] wdata[19:4] stall[3:0]
  localparam int NVEC = 8;
  localparam logic [46:0] VECS [NVEC] = '{
    {2'b00, 1'b1, 16'h1234, 4'h0, 4'h0, 16'h0000, 4'd0},  // R2 R7
    {2'b00, 1'b1, 16'hFFFF, 4'h0, 4'h0, 16'h0000, 4'd0},  // R3
    {2'b00, 1'b0, 16'h4040, 4'h0, 4'h0, 16'hFFFF, 4'd2},  // R4 R9
    {2'b01, 1'b1, 16'h2000, 4'h0, 4'h0, 16'hBEEF, 4'd1},  // R5 R9
    {2'b01, 1'b0, 16'h00FF, 4'h0, 4'h0, 16'h12C3, 4'd0},  // R6
    {2'b10, 1'b1, 16'hABCD, 4'h3, 4'hA, 16'h0000, 4'd0},  // R8 in
    {2'b11, 1'b0, 16'h7777, 4'hF, 4'h0, 16'h5566, 4'd3},  // R8 out
    {2'b01, 1'b1, 16'hFFFF, 4'h0, 4'h0, 16'hA1B2, 4'd0}   // R3 store
  };

  task automatic runOp(input logic [1:0] k, input logic w, input logic [15:0] a,
                       input logic [3:0] d, input logic [3:0] p,
                       input logic [15:0] wd, input int s, input string tag);
    int lat;
    int nb;
    logic isIo;
    logic [15:0] a0;
    logic [15:0] a1;
    logic [15:0] expRd;
    isIo  = k[1];
    nb    = (!isIo && w) ? 2 : 1;
    a0    = isIo ? {8'h00, d, p} : a;
    a1    = a0 + 16'd1;
    stall = s;
    @(negedge clk);
    logN = 0;
    reqValid = 1'b1; reqKind = k; reqWord = w; reqAddr = a;
    reqDev = d; reqPort = p; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    check(tag, "done latency (R10)", lat, nb * (s + 1) + 1);
    check(tag, "byte cycle count", logN, nb);
    check(tag, "first address", logAddr[0], a0);
    check(tag, "first memSel (R7)", logMem[0], !isIo);
    check(tag, "first direction", logWr[0], k[0]);
    if (nb == 2) begin
      check(tag, "second address", logAddr[1], a1);
      check(tag, "second memSel (R7)", logMem[1], 1'b1);
    end
    if (k[0]) begin
      if (nb == 2) begin
        check(tag, "high byte written first", logData[0], wd[15:8]);
        check(tag, "low byte written second", logData[1], wd[7:0]);
      end else begin
        check(tag, "single written byte", logData[0], wd[7:0]);
      end
    end else begin
      expRd = (nb == 2) ? {memByte(a0), memByte(a1)} : {8'h00, memByte(a0)};
      check(tag, "read data", rdData, expRd);
    end
    @(negedge clk);
    check(tag, "done single pulse (R10)", done, 1'b0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "busRead in reset", busRead, 0);
    check("R1", "busWrite in reset", busWrite, 0);
    check("R1", "memSel in reset", memSel, 0);
    check("R1", "done in reset", done, 0);
    check("R1", "idle in reset", idle, 1);
    check("R1", "rdData in reset", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "idle after release", idle, 1);
    check("R1", "no strobe after release", busRead | busWrite | memSel | done, 0);

    for (int i = 0; i < NVEC; i++) begin
      runOp(VECS[i][46:45], VECS[i][44], VECS[i][43:28], VECS[i][27:24],
            VECS[i][23:20], VECS[i][19:4], int'(VECS[i][3:0]),
            $sformatf("vector %0d", i));
    end

    // R11: request while busy is ignored
    stall = 3;
    @(negedge clk);
    logN = 0;
    reqValid = 1'b1; reqKind = 2'b00; reqWord = 1'b1; reqAddr = 16'h0810;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'b01; reqWord = 1'b0; reqAddr = 16'h3333;
    reqWdata = 16'h00EE;
    @(negedge clk);
    reqValid = 1'b0;
    begin
      int lat;
      lat = 2;
      while (!done && lat < 60) begin
        @(negedge clk);
        lat++;
      end
      check("R11", "latency unaffected", lat, 2 * 4 + 1);
    end
    check("R11", "only two byte cycles", logN, 2);
    check("R11", "both cycles are reads", logWr[0] | logWr[1], 0);
    check("R11", "result intact", rdData, {memByte(16'h0810), memByte(16'h0811)});
    repeat (4) @(negedge clk);
    check("R11", "no late bus cycle", logN, 2);
    check("R11", "bus quiet afterwards", busRead | busWrite, 0);

    finishRun();
  end

endmodule